// File: doc/BRIEF.md
# Posted Store Buffer for an L1 Data Cache

This block sits between the store/load port of a processor and a small direct-mapped L1 data array. A store is taken into a one-word holding register (address, 32-bit data, byte enables) and acknowledged in the same cycle it is presented. The processor can then carry on with non-memory work while the block writes the word into the cache behind its back. On a hit the write takes one cycle. On a miss the block first allocates the line: it requests it from the next level, takes the returned words one per cycle, and only then merges the held word into the line. Every committed store is also passed on to the next level as a one-cycle write-through strobe.

Any data access presented while the held store is still draining is stalled until the drain is complete. That covers a load or a second store alike. Loads use the same lookup. A load that hits is answered in the cycle it is presented. A load that misses stalls, has its line filled by the same fill engine, and is answered once the block is idle again. The next-level read side is a one-cycle request carrying a line-aligned address. After any latency, the line comes back as consecutive words, lowest offset first, qualified by a valid strobe.

Top module: `posted_store_buffer`

## Requirements
- R1: While the block is idle, a store request (`cpu_req`=1, `cpu_we`=1) is acknowledged in the same cycle (`cpu_ack`=1, `cpu_stall`=0), and its address, data and byte enables are held.
- R2: After a store is taken, `busy` is 1 from the next cycle until the held word is committed. A store that hits the cache commits in the cycle after it is taken, and `busy` is 0 one cycle later.
- R3: Whenever `busy` is 1, any request (load or store) sees `cpu_stall`=1 and `cpu_ack`=0.
- R4: A store that misses issues exactly one one-cycle `nl_req`, in the cycle after it is taken. The request carries the line-aligned address (low log2(4*LINE_WORDS) bits zero). The line is then written from LINE_WORDS words accepted on `nl_rvalid`, in offset order starting at offset 0.
- R5: After a store miss, the held word is merged into the cache only after the last fill word has been written, so no fill word overwrites it. The commit occurs in the cycle after the last fill word, and `busy` drops in the cycle after the commit.
- R6: Byte enable bit i selects bits 8i+7..8i of the stored word. Bytes whose enable bit is 0 keep their previous contents in the cache and at the next level.
- R7: While idle, a load that hits is acknowledged in the same cycle with the cached word on `cpu_rdata`. A load that misses is stalled and issues `nl_req` in that same cycle. When `busy` falls one cycle after the last fill word, the load is acknowledged with the filled data.
- R8: A load presented right after a store to the same address is stalled until the store drains, and then returns the stored value.
- R9: After reset, the holding register is empty, the drain state machine is idle, `busy`=0, and `nl_req` and `nl_st_valid` are 0.
- R10: Each committed store drives `nl_st_valid`=1 for exactly one cycle, with the store's address, data and byte enables on `nl_st_addr`, `nl_st_data` and `nl_st_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor presents a data access |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ack | output | 1 | Access accepted (stores) or answered (loads) this cycle |
| cpu_stall | output | 1 | Access presented but not accepted this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack on a load |
| busy | output | 1 | A posted store or a fill is in progress |
| nl_req | output | 1 | One-cycle line fill request to the next level |
| nl_addr | output | ADDR_W | Line-aligned fill address, valid with nl_req |
| nl_rvalid | input | 1 | Fill word valid |
| nl_rdata | input | 32 | Fill word |
| nl_st_valid | output | 1 | Write-through of a committed store |
| nl_st_addr | output | ADDR_W | Write-through address |
| nl_st_data | output | 32 | Write-through data |
| nl_st_be | output | 4 | Write-through byte enables |

## Verification
The bench aims at the stall boundary. Two back-to-back stores, and a load right behind a store, must stall exactly through the drain. A design that released one cycle early would ack into a full buffer or return stale load data. Fill latencies of one and three cycles test the merge ordering after a write miss: a block that merged before the fill finished would return fill data in place of the stored bytes. Partial byte enables, a conflict eviction and a refill of an earlier-written line test the byte lanes and the write-through path. Dropped write-through data would show up as an old value after the refill.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DRAIN = 2'd1,
    S_FILL  = 2'd2,
    S_MERGE = 2'd3
  } swb_state_e;

  // Byte-lane merge: lane b takes the new byte when its enable is set.
  function automatic logic [WORD_W-1:0] swb_merge(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] r;
    for (int b = 0; b < int'(BE_W); b++) begin
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/swb_post_reg.sv
module swb_post_reg import swb_pkg::*; #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              drop,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output logic              held,
  output logic [ADDR_W-1:0] held_addr,
  output logic [WORD_W-1:0] held_data,
  output logic [BE_W-1:0]   held_be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
    end else if (capture) begin
      held <= 1'b1;
    end else if (drop) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_data <= '0;
      held_be   <= '0;
    end else if (capture) begin
      held_addr <= in_addr;
      held_data <= in_data;
      held_be   <= in_be;
    end
  end

endmodule

// File: rtl/swb_line_store.sv
module swb_line_store import swb_pkg::*; #(
  parameter int unsigned SETS       = 8,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned TAG_W      = 25
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       rd_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_off,
  input  logic [TAG_W-1:0]              rd_tag,
  output logic                          rd_hit,
  output logic [WORD_W-1:0]             rd_word,
  input  logic                          wr_en,
  input  logic [$clog2(SETS)-1:0]       wr_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_off,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          tag_set,
  input  logic                          tag_clr,
  input  logic [$clog2(SETS)-1:0]       tag_idx,
  input  logic [TAG_W-1:0]              tag_val
);

  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned OFF_W = $clog2(LINE_WORDS);
  localparam int unsigned DEPTH = SETS * LINE_WORDS;

  logic              vld_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [WORD_W-1:0] dat_q [DEPTH];

  for (genvar s = 0; s < int'(SETS); s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
      end else if (tag_set && (tag_idx == IDX_W'(s))) begin
        vld_q[s] <= 1'b1;
        tag_q[s] <= tag_val;
      end else if (tag_clr && (tag_idx == IDX_W'(s))) begin
        vld_q[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dat_q[{wr_idx, wr_off}] <= wr_data;
    end
  end

  assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_word = dat_q[{rd_idx, rd_off}];

  logic unused_off_w;
  assign unused_off_w = (OFF_W == 0);

endmodule

// File: rtl/swb_drain_fsm.sv
module swb_drain_fsm import swb_pkg::*; #(
  parameter int unsigned LINE_W     = 27,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic                          lk_hit,
  input  logic [LINE_W-1:0]             lk_line,
  input  logic                          nl_rvalid,
  input  logic                          buf_held,
  output logic                          busy,
  output logic                          cpu_ack,
  output logic                          ev_capture,
  output logic                          ev_start_fill,
  output logic                          ev_fill_word,
  output logic                          ev_fill_done,
  output logic                          ev_store_commit,
  output logic [LINE_W-1:0]             fill_line,
  output logic [$clog2(LINE_WORDS)-1:0] fill_off
);

  localparam int unsigned OFF_W = $clog2(LINE_WORDS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  swb_state_e state_q, state_d;
  logic idle, load_miss, drain_hit, drain_miss;

  assign idle       = (state_q == S_IDLE);
  assign busy       = !idle;
  assign cpu_ack    = idle && cpu_req && (cpu_we || lk_hit);
  assign ev_capture = cpu_ack && cpu_we;
  assign load_miss  = idle && cpu_req && !cpu_we && !lk_hit;
  assign drain_hit  = (state_q == S_DRAIN) && lk_hit;
  assign drain_miss = (state_q == S_DRAIN) && !lk_hit;

  assign ev_start_fill   = load_miss || drain_miss;
  assign ev_fill_word    = (state_q == S_FILL) && nl_rvalid;
  assign ev_fill_done    = ev_fill_word && (fill_off == LAST_OFF);
  assign ev_store_commit = drain_hit || (state_q == S_MERGE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (ev_capture)     state_d = S_DRAIN;
        else if (load_miss) state_d = S_FILL;
      end
      S_DRAIN: state_d = drain_hit ? S_IDLE : S_FILL;
      S_FILL: begin
        if (ev_fill_done) state_d = buf_held ? S_MERGE : S_IDLE;
      end
      S_MERGE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_line <= '0;
      fill_off  <= '0;
    end else if (ev_start_fill) begin
      fill_line <= lk_line;
      fill_off  <= '0;
    end else if (ev_fill_word) begin
      fill_off  <= fill_off + OFF_W'(1);
    end
  end

endmodule

// File: rtl/posted_store_buffer.sv
module posted_store_buffer import swb_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SETS       = 8,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_be,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic [31:0]       cpu_rdata,
  output logic              busy,
  output logic              nl_req,
  output logic [ADDR_W-1:0] nl_addr,
  input  logic              nl_rvalid,
  input  logic [31:0]       nl_rdata,
  output logic              nl_st_valid,
  output logic [ADDR_W-1:0] nl_st_addr,
  output logic [31:0]       nl_st_data,
  output logic [3:0]        nl_st_be
);

  localparam int unsigned BYTE_W = $clog2(BE_W);
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int unsigned LINE_W = TAG_W + IDX_W;

  // Address arithmetic
  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: LINE_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: OFF_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] l);
    return l[LINE_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [LINE_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [LINE_W-1:0] l);
    return {l, {(OFF_W + BYTE_W){1'b0}}};
  endfunction

  // Named internal events
  logic              buf_held;
  logic [ADDR_W-1:0] buf_addr;
  logic [WORD_W-1:0] buf_data;
  logic [BE_W-1:0]   buf_be;
  logic              ev_capture, ev_start_fill, ev_fill_word, ev_fill_done, ev_store_commit;
  logic [LINE_W-1:0] fill_line;
  logic [OFF_W-1:0]  fill_off;

  logic [ADDR_W-1:0] lk_addr;
  logic [LINE_W-1:0] lk_line;
  logic              lk_hit;
  logic [WORD_W-1:0] rd_word;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [OFF_W-1:0]  wr_off;
  logic [WORD_W-1:0] wr_data;
  logic [IDX_W-1:0]  tag_idx;

  // One lookup port: the processor address while idle, the held store otherwise.
  assign lk_addr = busy ? buf_addr : cpu_addr;
  assign lk_line = line_of(lk_addr);

  swb_post_reg #(.ADDR_W(ADDR_W)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ev_capture),
    .drop      (ev_store_commit),
    .in_addr   (cpu_addr),
    .in_data   (cpu_wdata),
    .in_be     (cpu_be),
    .held      (buf_held),
    .held_addr (buf_addr),
    .held_data (buf_data),
    .held_be   (buf_be)
  );

  swb_drain_fsm #(.LINE_W(LINE_W), .LINE_WORDS(LINE_WORDS)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req         (cpu_req),
    .cpu_we          (cpu_we),
    .lk_hit          (lk_hit),
    .lk_line         (lk_line),
    .nl_rvalid       (nl_rvalid),
    .buf_held        (buf_held),
    .busy            (busy),
    .cpu_ack         (cpu_ack),
    .ev_capture      (ev_capture),
    .ev_start_fill   (ev_start_fill),
    .ev_fill_word    (ev_fill_word),
    .ev_fill_done    (ev_fill_done),
    .ev_store_commit (ev_store_commit),
    .fill_line       (fill_line),
    .fill_off        (fill_off)
  );

  // Fill words and the merged store share the single write port.
  assign wr_en   = ev_fill_word || ev_store_commit;
  assign wr_idx  = ev_fill_word ? idx_of(fill_line) : idx_of(lk_line);
  assign wr_off  = ev_fill_word ? fill_off : off_of(lk_addr);
  assign wr_data = ev_fill_word ? nl_rdata : swb_merge(rd_word, buf_data, buf_be);
  assign tag_idx = ev_fill_done ? idx_of(fill_line) : idx_of(lk_line);

  swb_line_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx_of(lk_line)),
    .rd_off  (off_of(lk_addr)),
    .rd_tag  (tag_of(lk_line)),
    .rd_hit  (lk_hit),
    .rd_word (rd_word),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_off  (wr_off),
    .wr_data (wr_data),
    .tag_set (ev_fill_done),
    .tag_clr (ev_start_fill),
    .tag_idx (tag_idx),
    .tag_val (tag_of(fill_line))
  );

  assign cpu_stall   = cpu_req && !cpu_ack;
  assign cpu_rdata   = rd_word;
  assign nl_req      = ev_start_fill;
  assign nl_addr     = base_of(lk_line);
  assign nl_st_valid = ev_store_commit;
  assign nl_st_addr  = buf_addr;
  assign nl_st_data  = buf_data;
  assign nl_st_be    = buf_be;

  logic unused_low_bits;
  assign unused_low_bits = ^lk_addr[BYTE_W-1:0];

endmodule

// File: rtl/swb_checker.sv
module swb_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_req,
  input logic cpu_we,
  input logic cpu_ack,
  input logic cpu_stall,
  input logic busy,
  input logic nl_req,
  input logic nl_st_valid,
  input logic buf_held,
  input logic ev_capture,
  input logic ev_fill_done,
  input logic ev_store_commit
);

  // R1: an idle block takes a store in the cycle it appears
  a_r1_store_taken_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !busy) |-> cpu_ack);

  // R2: a captured store leaves the block busy and the register full
  a_r2_busy_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> (busy && buf_held));

  // R3: nothing is accepted while a drain or fill is running
  a_r3_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && busy) |-> (cpu_stall && !cpu_ack));

  // R4: the fill request is a single-cycle strobe
  a_r4_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req |=> !nl_req);

  // R5: the held word is committed right after the last fill word
  a_r5_merge_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill_done && buf_held) |=> ev_store_commit);

  // R10: a commit empties the register and frees the block
  a_r10_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    nl_st_valid |=> (!busy && !buf_held));

endmodule

bind posted_store_buffer swb_checker u_swb_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_req         (cpu_req),
  .cpu_we          (cpu_we),
  .cpu_ack         (cpu_ack),
  .cpu_stall       (cpu_stall),
  .busy            (busy),
  .nl_req          (nl_req),
  .nl_st_valid     (nl_st_valid),
  .buf_held        (buf_held),
  .ev_capture      (ev_capture),
  .ev_fill_done    (ev_fill_done),
  .ev_store_commit (ev_store_commit)
);

// File: tb/test_posted_store_buffer.sv
module test_posted_store_buffer;

  localparam int LW     = 4;
  localparam int NSETS  = 8;
  localparam int LINE_B = LW * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ack, cpu_stall, busy, nl_req, nl_st_valid;
  logic [31:0] cpu_rdata, nl_addr, nl_st_addr, nl_st_data;
  logic [3:0]  nl_st_be;
  logic        nl_rvalid = 1'b0;
  logic [31:0] nl_rdata = '0;

  always #5 clk = ~clk;

  posted_store_buffer #(.ADDR_W(32), .SETS(NSETS), .LINE_WORDS(LW)) i_posted_store_buffer (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
    .cpu_rdata(cpu_rdata), .busy(busy), .nl_req(nl_req), .nl_addr(nl_addr),
    .nl_rvalid(nl_rvalid), .nl_rdata(nl_rdata), .nl_st_valid(nl_st_valid),
    .nl_st_addr(nl_st_addr), .nl_st_data(nl_st_data), .nl_st_be(nl_st_be)
  );

  int checks = 0, errors = 0, cyc = 0, lat = 2;
  int idle_from = 0, req_at = -1, st_at = -1;
  logic [31:0] req_base = '0, st_a = '0, st_d = '0;
  logic [3:0]  st_b = '0;
  bit          filling = 1'b0;
  int          f_cyc = 0;
  logic [31:0] f_base = '0;
  bit          done = 1'b0;
  logic [31:0] nmem [int];
  logic [31:0] amem [int];
  int          mtag [int];

  function automatic logic [31:0] init_val(int k);
    return (32'(k) * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] nmem_rd(logic [31:0] a);
    int k = int'(a >> 2);
    return nmem.exists(k) ? nmem[k] : init_val(k);
  endfunction

  function automatic logic [31:0] amem_rd(logic [31:0] a);
    int k = int'(a >> 2);
    return amem.exists(k) ? amem[k] : init_val(k);
  endfunction

  // Byte lanes: enable bit i owns bits 8i+7..8i
  function automatic logic [31:0] lanes(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  function automatic int set_of(logic [31:0] a);
    return int'((a / LINE_B) % NSETS);
  endfunction

  function automatic int tag_of(logic [31:0] a);
    return int'(a / (LINE_B * NSETS));
  endfunction

  function automatic bit m_hit(logic [31:0] a);
    return mtag.exists(set_of(a)) && (mtag[set_of(a)] == tag_of(a));
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit rq, input bit we, input logic [31:0] a,
                      input logic [31:0] d, input logic [3:0] be, output bit acked);
    bit e_busy, e_ack, hit;
    @(posedge clk);
    cyc++;
    #1;
    cpu_req = rq; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    if (filling && cyc >= f_cyc + lat && cyc < f_cyc + lat + LW) begin
      nl_rvalid = 1'b1;
      nl_rdata  = nmem_rd(f_base + 32'((cyc - f_cyc - lat) * 4));
      if (cyc == f_cyc + lat + LW - 1) filling = 1'b0;
    end else begin
      nl_rvalid = 1'b0;
      nl_rdata  = '0;
    end
    #3;
    e_busy = (cyc < idle_from);
    hit    = m_hit(a);
    e_ack  = rq && !e_busy && (we || hit);
    if (rq && !we && !e_busy && !hit) begin
      req_at = cyc; req_base = a & ~32'(LINE_B - 1);
      idle_from = cyc + lat + LW;
      mtag[set_of(a)] = tag_of(a);
    end
    chk(busy == e_busy, "R2/R3", "busy", 32'(busy), 32'(e_busy));
    chk(cpu_ack == e_ack, e_busy ? "R3" : (we ? "R1" : "R7"), "cpu_ack", 32'(cpu_ack), 32'(e_ack));
    chk(cpu_stall == (rq && !e_ack), "R3", "cpu_stall", 32'(cpu_stall), 32'(rq && !e_ack));
    chk(nl_req == (cyc == req_at), "R4", "nl_req", 32'(nl_req), 32'(cyc == req_at));
    if (nl_req) begin
      chk(nl_addr == req_base, "R4", "nl_addr", nl_addr, req_base);
      filling = 1'b1; f_cyc = cyc; f_base = nl_addr;
    end
    chk(nl_st_valid == (cyc == st_at), "R10", "nl_st_valid", 32'(nl_st_valid), 32'(cyc == st_at));
    if (nl_st_valid) begin
      chk(nl_st_addr == st_a, "R10", "nl_st_addr", nl_st_addr, st_a);
      chk(nl_st_data == st_d, "R10", "nl_st_data", nl_st_data, st_d);
      chk(nl_st_be == st_b, "R6", "nl_st_be", 32'(nl_st_be), 32'(st_b));
      nmem[int'(nl_st_addr >> 2)] = lanes(nmem_rd(nl_st_addr), nl_st_data, nl_st_be);
    end
    if (e_ack && we) begin
      amem[int'(a >> 2)] = lanes(amem_rd(a), d, be);
      st_a = a; st_d = d; st_b = be;
      if (hit) begin
        st_at = cyc + 1; idle_from = cyc + 2;
      end else begin
        req_at = cyc + 1; req_base = a & ~32'(LINE_B - 1);
        st_at = cyc + lat + LW + 1; idle_from = cyc + lat + LW + 2;
        mtag[set_of(a)] = tag_of(a);
      end
    end
    if (e_ack && !we) begin
      chk(cpu_rdata == amem_rd(a), "R7/R8", "cpu_rdata", cpu_rdata, amem_rd(a));
    end
    acked = cpu_ack;
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    bit ak = 1'b0;
    for (int n = 0; n < 100 && !ak; n++) step(1'b1, we, a, d, be, ak);
    chk(ak, "R3", "access completed", 32'(ak), 32'd1);
  endtask

  task automatic idle(input int n);
    bit ak;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, ak);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    // R9: reset state
    chk(busy == 1'b0, "R9", "busy", 32'(busy), 32'd0);
    chk(nl_req == 1'b0, "R9", "nl_req", 32'(nl_req), 32'd0);
    chk(nl_st_valid == 1'b0, "R9", "nl_st_valid", 32'(nl_st_valid), 32'd0);
    idle(2);

    // R4 R5 R8: store miss with fill, then a load to the same address right behind it
    lat = 2;
    access(1'b1, 32'h0000_0104, 32'hCAFE_0001, 4'hF);
    access(1'b0, 32'h0000_0104, '0, '0);
    // R6: partial lanes on a hit, read back
    access(1'b1, 32'h0000_0108, 32'h1122_3344, 4'b0101);
    access(1'b0, 32'h0000_0108, '0, '0);
    // R3: back-to-back stores, second one stalls for the hit drain
    access(1'b1, 32'h0000_010C, 32'hAAAA_5555, 4'hF);
    access(1'b1, 32'h0000_0100, 32'h0F0F_F0F0, 4'b1100);
    idle(3);
    // R7: load miss that evicts the written line, then refill it and see written data
    lat = 3;
    idle(1);
    access(1'b0, 32'h0000_2104, '0, '0);
    access(1'b0, 32'h0000_0100, '0, '0);
    access(1'b0, 32'h0000_0104, '0, '0);
    access(1'b0, 32'h0000_010C, '0, '0);
    // R5 R6: store miss with one byte lane, minimum latency, then load it back
    lat = 1;
    idle(1);
    access(1'b1, 32'h0000_03F8, 32'hDE00_0000, 4'b1000);
    access(1'b0, 32'h0000_03F8, '0, '0);
    // R2: background drain with idle cycles, then mixed traffic
    access(1'b1, 32'h0000_03F0, 32'h7777_0000, 4'b0011);
    idle(4);
    access(1'b0, 32'h0000_03F0, '0, '0);
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a = 32'h0000_0400 + 32'((i * 52) % 640);
      a[1:0] = 2'b00;
      if (i % 6 == 3) begin lat = 1 + (i % 3); idle(1); end
      access(1'b1, a, 32'(i) * 32'h0101_0101 ^ 32'h8000_0001, 4'(i % 15 + 1));
      if (i % 2 == 0) access(1'b0, a, '0, '0);
      if (i % 5 == 0) idle(2);
    end
    idle(3);
    finish_run();
  end

endmodule